// File: doc/BRIEF.md
# USB Device Status and Wake Monitor

This block collects device-side status for a USB 2.0 device controller and presents it as one read-only 32-bit status word. On every received start-of-frame token it captures the frame number. The packing of that number depends on the link speed: high-speed links carry a microframe index below the millisecond frame, and full-speed links do not.

The block also watches the PHY receive handshake lines. If either `phy_rxvalid` or `phy_rxactive` stays high without a break for 2 ms, the block raises a sticky PHY error and forces the device into suspend. It also pulses the early-suspend interrupt, so that software can read the error flag and tell this cause apart from an ordinary bus-idle suspend.

The third function gates the software request for remote-wakeup resume signaling. A request only goes through when the remote-wakeup configuration bit is set and the host has already enabled the feature. Resume signaling then runs for a fixed number of cycles and clears itself.

Top module: `usb_dev_status_mon`

## Requirements
- R1: After reset the status word is zero. The timestamp field in bits [31:18] changes only on a cycle where `sof_vld` is high, and shows the new value from the next cycle. Between tokens it holds its value.
- R2: When `hs_mode`=1 at the token, bits [31:21] take the 11-bit frame number and bits [20:18] take the 3-bit microframe number.
- R3: When `hs_mode`=0 at the token, bits [28:18] take the 11-bit frame number and bits [31:29] read 0.
- R4: `phy_err` (status bit 16) rises after TIMEOUT = CLK_HZ/500 consecutive clock edges at which `phy_rxvalid` or `phy_rxactive` is high. Any edge where both lines are low restarts the count.
- R5: `suspend` is high exactly while `phy_err` is high. `early_susp_irq` is a single-cycle pulse in the first cycle `phy_err` is high.
- R6: Status bit 17 and bits [15:0] always read 0.
- R7: `phy_err` stays set until an `err_clr` strobe. The strobe clears it, takes priority over a new detection, and restarts the TIMEOUT window.
- R8: `resume_req` starts resume signaling only when both `cfg_rwake_en` and `host_rwake_en` are high. Otherwise the request has no effect.
- R9: A granted request drives `resume_sig` high for RESUME_CYC cycles, starting the next cycle, and then clears it. A request made while signaling is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_mode | input | 1 | 1 = high-speed link, 0 = full-speed link |
| sof_vld | input | 1 | Start-of-frame token received this cycle |
| sof_frame | input | 11 | Millisecond frame number of the token |
| sof_uframe | input | 3 | Microframe number of the token (high-speed only) |
| phy_rxvalid | input | 1 | PHY receive data valid |
| phy_rxactive | input | 1 | PHY receive active |
| cfg_rwake_en | input | 1 | Remote wakeup supported by configuration |
| host_rwake_en | input | 1 | Host has enabled the remote wakeup feature |
| resume_req | input | 1 | Software request for resume signaling |
| err_clr | input | 1 | Clear strobe for the PHY error |
| status_word | output | 32 | Read-only status word |
| phy_err | output | 1 | Sticky PHY stuck error |
| suspend | output | 1 | Forced suspend due to a PHY error |
| early_susp_irq | output | 1 | Early-suspend interrupt pulse |
| resume_sig | output | 1 | Resume signaling active toward the host |

## Verification
The hardest situation to reach is the edge of the stuck-line window. The error must appear after exactly TIMEOUT busy edges, and a single idle cycle one edge before expiry must prevent it. The bench overrides the clock-frequency parameter so the window is 20 cycles. It then holds the lines for 19 edges, inserts one idle cycle, alternates `phy_rxvalid` and `phy_rxactive` without a gap, and strobes `err_clr` while the lines are still stuck, which shows that the window restarts. A cycle-accurate behavioural model predicts every output on every clock.

// File: rtl/usb_stat_pkg.sv
package usb_stat_pkg;
  localparam int unsigned FRAME_W  = 11;
  localparam int unsigned UFRAME_W = 3;
  localparam int unsigned STAMP_W  = FRAME_W + UFRAME_W;

  // Pack a start-of-frame number into the 14-bit timestamp field.
  function automatic logic [STAMP_W-1:0] pack_stamp(
    input logic                hs,
    input logic [FRAME_W-1:0]  frame,
    input logic [UFRAME_W-1:0] uframe
  );
    logic [STAMP_W-1:0] v;
    if (hs) v = {frame, uframe};
    else    v = {{UFRAME_W{1'b0}}, frame};
    return v;
  endfunction
endpackage

// File: rtl/usb_sof_stamp.sv
module usb_sof_stamp
  import usb_stat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_mode,
  input  logic                sof_vld,
  input  logic [FRAME_W-1:0]  sof_frame,
  input  logic [UFRAME_W-1:0] sof_uframe,
  output logic [STAMP_W-1:0]  stamp
);
  logic [STAMP_W-1:0] next_stamp;
  assign next_stamp = pack_stamp(hs_mode, sof_frame, sof_uframe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stamp <= '0;
    else if (sof_vld) stamp <= next_stamp;
  end

  // R1: the field holds between tokens
  assert_stamp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_vld |=> $stable(stamp));
  // R3: a full-speed token leaves the top three bits clear
  assert_fs_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_vld && !hs_mode) |=> (stamp[STAMP_W-1:FRAME_W] == '0));
  // R2: a high-speed token puts the microframe in the low bits
  assert_hs_uframe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_vld && hs_mode) |=> (stamp[UFRAME_W-1:0] == $past(sof_uframe)));
endmodule

// File: rtl/usb_phy_stuck_wdog.sv
module usb_phy_stuck_wdog #(
  parameter int unsigned LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxvalid,
  input  logic rxactive,
  input  logic err_clr,
  output logic phy_err,
  output logic err_irq
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          busy;
  logic          trip;

  assign busy = rxvalid | rxactive;
  assign trip = busy && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      phy_err <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      err_irq <= trip && !phy_err && !err_clr;
      if (err_clr) begin
        phy_err <= 1'b0;
        cnt     <= '0;
      end else if (!busy) begin
        cnt <= '0;
      end else if (trip) begin
        phy_err <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: the error never rises after an idle cycle
  assert_err_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_err) |-> $past(busy));
  // R7: sticky without a clear strobe
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_err && !err_clr) |=> phy_err);
  // R7: a clear strobe always drops the flag
  assert_clr_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !phy_err);
  // R5: the interrupt is a single pulse and comes with the error
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);
  assert_irq_with_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> phy_err);
endmodule

// File: rtl/usb_resume_gate.sv
module usb_resume_gate #(
  parameter int unsigned RESUME_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_rwake_en,
  input  logic host_rwake_en,
  input  logic resume_req,
  output logic resume_sig
);
  localparam int unsigned RW = $clog2(RESUME_CYC + 1);

  logic [RW-1:0] rcnt;
  logic          active;
  logic          grant;

  assign active     = (rcnt != '0);
  assign grant      = resume_req && cfg_rwake_en && host_rwake_en && !active;
  assign resume_sig = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rcnt <= '0;
    else if (active) rcnt <= rcnt - 1'b1;
    else if (grant)  rcnt <= RW'(RESUME_CYC);
  end

  // R8: signaling starts only with both enables present
  assert_gate_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_sig) |-> $past(cfg_rwake_en && host_rwake_en && resume_req));
  // R9: an active window counts down and is never reloaded
  assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (rcnt == $past(rcnt) - 1'b1));
endmodule

// File: rtl/usb_dev_status_mon.sv
module usb_dev_status_mon
  import usb_stat_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned RESUME_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hs_mode,
  input  logic        sof_vld,
  input  logic [10:0] sof_frame,
  input  logic [2:0]  sof_uframe,
  input  logic        phy_rxvalid,
  input  logic        phy_rxactive,
  input  logic        cfg_rwake_en,
  input  logic        host_rwake_en,
  input  logic        resume_req,
  input  logic        err_clr,
  output logic [31:0] status_word,
  output logic        phy_err,
  output logic        suspend,
  output logic        early_susp_irq,
  output logic        resume_sig
);
  localparam int unsigned TIMEOUT_CYC = (CLK_HZ / 500 < 2) ? 2 : CLK_HZ / 500;
  localparam int unsigned STAMP_LSB   = 32 - STAMP_W;
  localparam int unsigned ERR_BIT     = 16;

  logic [STAMP_W-1:0] stamp;

  usb_sof_stamp u_stamp (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_mode    (hs_mode),
    .sof_vld    (sof_vld),
    .sof_frame  (sof_frame),
    .sof_uframe (sof_uframe),
    .stamp      (stamp)
  );

  usb_phy_stuck_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxvalid  (phy_rxvalid),
    .rxactive (phy_rxactive),
    .err_clr  (err_clr),
    .phy_err  (phy_err),
    .err_irq  (early_susp_irq)
  );

  usb_resume_gate #(.RESUME_CYC(RESUME_CYC)) u_wake (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_rwake_en  (cfg_rwake_en),
    .host_rwake_en (host_rwake_en),
    .resume_req    (resume_req),
    .resume_sig    (resume_sig)
  );

  assign suspend = phy_err;

  always_comb begin
    status_word                    = '0;
    status_word[31:STAMP_LSB]      = stamp;
    status_word[ERR_BIT]           = phy_err;
  end

  // R6: reserved positions stay clear
  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[17] == 1'b0) && (status_word[15:0] == 16'h0));
endmodule

// File: tb/sim_usb_dev_status_mon.sv
module sim_usb_dev_status_mon;
  localparam int unsigned CLK_HZ = 10_000;
  localparam int unsigned RC     = 6;
  localparam int LIM = CLK_HZ / 500; // 2 ms window in cycles

  logic clk = 0;
  logic rst_n = 0;
  logic hs_mode = 0, sof_vld = 0;
  logic [10:0] sof_frame = 0;
  logic [2:0]  sof_uframe = 0;
  logic phy_rxvalid = 0, phy_rxactive = 0;
  logic cfg_rwake_en = 0, host_rwake_en = 0, resume_req = 0, err_clr = 0;
  logic [31:0] status_word;
  logic phy_err, suspend, early_susp_irq, resume_sig;

  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  usb_dev_status_mon #(.CLK_HZ(CLK_HZ), .RESUME_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .sof_vld(sof_vld),
    .sof_frame(sof_frame), .sof_uframe(sof_uframe),
    .phy_rxvalid(phy_rxvalid), .phy_rxactive(phy_rxactive),
    .cfg_rwake_en(cfg_rwake_en), .host_rwake_en(host_rwake_en),
    .resume_req(resume_req), .err_clr(err_clr),
    .status_word(status_word), .phy_err(phy_err), .suspend(suspend),
    .early_susp_irq(early_susp_irq), .resume_sig(resume_sig)
  );

  // behavioural reference
  int m_stamp = 0, m_run = 0, m_err = 0, m_irq = 0, m_rleft = 0;
  bit m_last_hs = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stamp = 0; m_run = 0; m_err = 0; m_irq = 0; m_rleft = 0;
    end else begin
      if (sof_vld) begin
        m_last_hs = hs_mode;
        m_stamp = hs_mode ? (sof_frame * 8 + sof_uframe) : sof_frame;
      end
      m_irq = 0;
      if (err_clr) begin
        m_err = 0; m_run = 0;
      end else if (!(phy_rxvalid || phy_rxactive)) begin
        m_run = 0;
      end else begin
        m_run = m_run + 1;
        if (m_run >= LIM) begin
          if (m_err == 0) m_irq = 1;
          m_err = 1;
        end
      end
      if (m_rleft > 0) m_rleft = m_rleft - 1;
      else if (resume_req && cfg_rwake_en && host_rwake_en) m_rleft = RC;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_last_hs ? "R2 stamp" : "R3 stamp", {18'h0, status_word[31:18]}, m_stamp);
      chk("R6 reserved", {status_word[17], status_word[15:0]}, 0);
      chk("R4/R7 phy_err", {31'h0, status_word[16]}, m_err);
      chk("R4/R7 phy_err pin", {31'h0, phy_err}, m_err);
      chk("R5 suspend", {31'h0, suspend}, m_err);
      chk("R5 early_susp_irq", {31'h0, early_susp_irq}, m_irq);
      chk("R8/R9 resume_sig", {31'h0, resume_sig}, (m_rleft != 0) ? 1 : 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sof(input bit hs, input int fr, input int uf);
    @(negedge clk);
    hs_mode = hs; sof_frame = 11'(fr); sof_uframe = 3'(uf); sof_vld = 1;
    @(negedge clk);
    sof_vld = 0; sof_frame = 11'h5a5; sof_uframe = 3'h5;
  endtask

  task automatic pulse_req(input bit c, input bit h);
    @(negedge clk);
    cfg_rwake_en = c; host_rwake_en = h; resume_req = 1;
    @(negedge clk);
    resume_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    chk("R1 reset word", status_word, 0);
    chk("R1 reset flags", {28'h0, phy_err, suspend, early_susp_irq, resume_sig}, 0);
    step(2);
    rst_n = 1;
    step(2);
    // R1/R3 full-speed tokens, holds between them
    sof(0, 11'h123, 7);
    step(5);
    sof(0, 11'h7ff, 3);
    step(3);
    // R2 high-speed tokens including the top frame and microframe
    sof(1, 11'h7ff, 7);
    step(2);
    sof(1, 11'h001, 2);
    sof(1, 11'h400, 0);
    // back-to-back token with speed change
    @(negedge clk); hs_mode = 0; sof_frame = 11'h2aa; sof_vld = 1;
    @(negedge clk); hs_mode = 1; sof_frame = 11'h155; sof_uframe = 4; sof_vld = 1;
    @(negedge clk); sof_vld = 0;
    step(2);
    // R4 gap one edge before expiry restarts the window
    phy_rxvalid = 1; step(LIM - 1);
    phy_rxvalid = 0; step(1);
    phy_rxvalid = 1; step(LIM - 1);
    phy_rxvalid = 0; step(3);
    // R4 alternating lines without a gap count as one stuck run
    for (int i = 0; i < LIM + 4; i++) begin
      phy_rxvalid = i[0]; phy_rxactive = ~i[0]; step(1);
    end
    // R7 sticky while lines go idle
    phy_rxvalid = 0; phy_rxactive = 0; step(10);
    // R7 clear while still stuck: window restarts
    phy_rxactive = 1;
    err_clr = 1; step(1); err_clr = 0;
    step(LIM + 5);
    phy_rxactive = 0; step(2);
    err_clr = 1; step(1); err_clr = 0;
    step(3);
    // R8 request gated by both enables
    pulse_req(1, 0); step(4);
    pulse_req(0, 1); step(4);
    pulse_req(0, 0); step(4);
    pulse_req(1, 1); step(2);
    // R9 request during active window ignored
    pulse_req(1, 1); step(RC + 3);
    // R9 held request re-grants only after expiry
    @(negedge clk); resume_req = 1; step(3 * RC);
    resume_req = 0; step(RC + 2);
    // R1 reset mid-run clears all
    phy_rxvalid = 1; step(5);
    rst_n = 0; step(2);
    chk("R1 reset word again", status_word, 0);
    rst_n = 1; phy_rxvalid = 0; step(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule